// File: doc/BRIEF.md
# Parallel Bit Gather/Scatter Unit

This block moves individual bits of a data word under the control of a mask word. Gather (extract) collects the data bits that sit under set mask bits and packs them, lowest index first, into the bottom of the result. Scatter (deposit) is the inverse. It takes the data bits from bit 0 upward and places them, in order, into the set mask positions. All other result bits are cleared.

A caller presents a data word, a mask word, an operation select and a width select together with a valid strobe. The result appears on the output register one clock later, flagged by its own valid bit. In narrow (32-bit) mode the upper halves of the operands play no part, and the upper half of the result is zero. How the rank of each mask bit is computed is a parameter: either a ripple chain or an independent population count per bit.

Top module: `bit_gather_scatter`

## Requirements
- R1: `out_valid` equals the value `in_valid` had one clock earlier. While `rst_n` is low, `out_valid` and `out_result` are both 0.
- R2: For gather (`in_op` = 0), walk the set bits of the effective mask in increasing index order. The data bit at the n-th such position (n counted from 0) appears at result bit n.
- R3: For gather, every result bit whose index is at or above the number of set bits in the effective mask is 0.
- R4: For scatter (`in_op` = 1), walk the set bits of the effective mask from lowest to highest. The n-th such position (n counted from 0) receives data bit n.
- R5: For scatter, every result bit whose effective mask bit is clear is 0.
- R6: With `in_wide` = 0, only bits 31:0 of `in_data` and `in_mask` are used, and bits 63:32 of the result are 0. With `in_wide` = 1, all 64 bits are used.
- R7: An effective mask of all zeros gives an all-zero result for both operations.
- R8: An effective mask of all ones returns the effective data unchanged for both operations.
- R9: In a cycle with `in_valid` low, `out_result` keeps its previous value.
- R10: With data bits 7..0 = 1,0,1,1,0,1,1,0 (0xB6) and mask 0x65, gather returns 0x06 and scatter returns 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| in_op | input | 1 | 0 = gather (extract), 1 = scatter (deposit) |
| in_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| in_data | input | 64 | Data word |
| in_mask | input | 64 | Mask word selecting bit positions |
| out_valid | output | 1 | Result register holds a fresh result |
| out_result | output | 64 | Registered result |

## Verification
The assertions assume that `in_valid`, `in_op` and `in_wide` carry defined values in every cycle after reset. They also assume that `in_valid` is low during reset, so the first sampled history after reset is a known idle cycle. The bench drives every input at the falling edge only, always with a defined value, and holds `in_valid` at 0 for the whole of reset. It also drives garbage into the upper operand halves during narrow operations and into all operands during idle cycles, which exercises the ignore and hold properties without breaking what the assertions rely on.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

   typedef enum logic {
      BGS_GATHER  = 1'b0,
      BGS_SCATTER = 1'b1
   } bgs_op_e;

   typedef enum int {
      BGS_RANK_RIPPLE = 0,
      BGS_RANK_POPCNT = 1
   } bgs_rank_style_e;

endpackage

// File: rtl/bgs_rank.sv
// Per-position rank: number of set mask bits strictly below each index.
module bgs_rank #(
   parameter int XLEN       = 64,
   parameter int RANK_STYLE = 1,
   localparam int IDXW      = $clog2(XLEN + 1)
) (
   input  logic [XLEN-1:0]           mask,
   output logic [XLEN-1:0][IDXW-1:0] rank
);

   if (RANK_STYLE == int'(bgs_pkg::BGS_RANK_RIPPLE)) begin : g_ripple
      assign rank[0] = '0;
      for (genvar i = 1; i < XLEN; i++) begin : g_pos
         assign rank[i] = rank[i-1] + IDXW'(mask[i-1]);
      end
   end else if (RANK_STYLE == int'(bgs_pkg::BGS_RANK_POPCNT)) begin : g_popcnt
      for (genvar i = 0; i < XLEN; i++) begin : g_pos
         localparam logic [XLEN-1:0] BELOW = (XLEN'(1) << i) - XLEN'(1);
         assign rank[i] = IDXW'($countones(mask & BELOW));
      end
   end else begin : g_bad_style
      $error("bgs_rank: unknown RANK_STYLE");
   end

endmodule

// File: rtl/bgs_gather.sv
// Gather: result bit k is the data bit under the mask bit whose rank is k.
module bgs_gather #(
   parameter int XLEN  = 64,
   localparam int IDXW = $clog2(XLEN + 1)
) (
   input  logic [XLEN-1:0]           data,
   input  logic [XLEN-1:0]           mask,
   input  logic [XLEN-1:0][IDXW-1:0] rank,
   output logic [XLEN-1:0]           result
);

   for (genvar k = 0; k < XLEN; k++) begin : g_out
      logic [XLEN-1:0] hit;
      for (genvar i = 0; i < XLEN; i++) begin : g_src
         assign hit[i] = mask[i] & (rank[i] == IDXW'(k)) & data[i];
      end
      assign result[k] = |hit;
   end

endmodule

// File: rtl/bgs_scatter.sv
// Scatter: a set mask bit at index i receives the data bit indexed by its rank.
module bgs_scatter #(
   parameter int XLEN  = 64,
   localparam int IDXW = $clog2(XLEN + 1),
   localparam int SELW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0]           data,
   input  logic [XLEN-1:0]           mask,
   input  logic [XLEN-1:0][IDXW-1:0] rank,
   output logic [XLEN-1:0]           result
);

   for (genvar i = 0; i < XLEN; i++) begin : g_dst
      // rank[i] <= i < XLEN, so its top bit is always clear
      assign result[i] = mask[i] & ~rank[i][SELW] & data[rank[i][SELW-1:0]];
   end

endmodule

// File: rtl/bit_gather_scatter.sv
module bit_gather_scatter #(
   parameter int XLEN       = 64,
   parameter int NARROW     = 32,
   parameter int RANK_STYLE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_op,
   input  logic            in_wide,
   input  logic [XLEN-1:0] in_data,
   input  logic [XLEN-1:0] in_mask,
   output logic            out_valid,
   output logic [XLEN-1:0] out_result
);

   import bgs_pkg::*;

   localparam int IDXW = $clog2(XLEN + 1);
   localparam logic [XLEN-1:0] NARROW_ONES = (XLEN'(1) << NARROW) - XLEN'(1);
   localparam logic [XLEN-1:0] WIDE_ONES   = '1;

   if ((XLEN & (XLEN - 1)) != 0 || XLEN < 2) begin : g_bad_xlen
      $error("bit_gather_scatter: XLEN must be a power of two");
   end
   if (NARROW < 1 || NARROW >= XLEN) begin : g_bad_narrow
      $error("bit_gather_scatter: NARROW must lie in 1..XLEN-1");
   end

   // ---- width select --------------------------------------------------
   logic [XLEN-1:0] width_ones;
   logic [XLEN-1:0] eff_data;
   logic [XLEN-1:0] eff_mask;

   assign width_ones = in_wide ? WIDE_ONES : NARROW_ONES;
   assign eff_data   = in_data & width_ones;
   assign eff_mask   = in_mask & width_ones;

   // ---- datapath -------------------------------------------------------
   logic [XLEN-1:0][IDXW-1:0] rank;
   logic [XLEN-1:0]           gather_res;
   logic [XLEN-1:0]           scatter_res;
   logic [XLEN-1:0]           next_result;
   bgs_op_e                   op;

   assign op = bgs_op_e'(in_op);

   bgs_rank #(.XLEN(XLEN), .RANK_STYLE(RANK_STYLE)) u_rank (
      .mask (eff_mask),
      .rank (rank)
   );

   bgs_gather #(.XLEN(XLEN)) u_gather (
      .data   (eff_data),
      .mask   (eff_mask),
      .rank   (rank),
      .result (gather_res)
   );

   bgs_scatter #(.XLEN(XLEN)) u_scatter (
      .data   (eff_data),
      .mask   (eff_mask),
      .rank   (rank),
      .result (scatter_res)
   );

   always_comb begin
      unique case (op)
         BGS_GATHER:  next_result = gather_res;
         BGS_SCATTER: next_result = scatter_res;
         default:     next_result = '0;
      endcase
   end

   // ---- output register -----------------------------------------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= next_result;
         end
      end
   end

   // ---- assertions ----------------------------------------------------
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_gather_high_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BGS_GATHER) |=>
         ((out_result >> $past($countones(eff_mask))) == '0));
   p_scatter_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BGS_SCATTER) |=>
         ((out_result & ~$past(eff_mask)) == '0));
   p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wide) |=> ((out_result & ~NARROW_ONES) == '0));
   p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && eff_mask == '0) |=> (out_result == '0));
   p_full_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && eff_mask == width_ones) |=> (out_result == $past(eff_data)));
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));

endmodule

// File: tb/tb_bit_gather_scatter.sv
`timescale 1ns/1ps
module tb_bit_gather_scatter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_op;
   logic        in_wide;
   logic [63:0] in_data;
   logic [63:0] in_mask;
   logic        out_valid;
   logic [63:0] out_result;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   finished = 0;

   logic [63:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   bit_gather_scatter dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_op      (in_op),
      .in_wide    (in_wide),
      .in_data    (in_data),
      .in_mask    (in_mask),
      .out_valid  (out_valid),
      .out_result (out_result)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Loop reference built from the requirements (R2, R4, R6)
   function automatic logic [63:0] ref_model(input logic op, input logic wide,
                                             input logic [63:0] d, input logic [63:0] m);
      logic [63:0] r = '0;
      int k = 0;
      int w = wide ? 64 : 32;
      for (int i = 0; i < w; i++) begin
         if (m[i]) begin
            if (!op) r[k] = d[i];
            else     r[i] = d[k];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic send(input logic op, input logic wide, input logic [63:0] d,
                       input logic [63:0] m, input logic [63:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_wide  = wide;
      in_data  = d;
      in_mask  = m;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic send_ref(input logic op, input logic wide, input logic [63:0] d,
                           input logic [63:0] m, input string tag);
      send(op, wide, d, m, ref_model(op, wide, d, m), tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor: pops the scoreboard whenever a result is flagged valid
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected out_valid", 64'd1, 64'd0);
         end else begin
            check(tag_q.pop_front(), out_result, exp_q.pop_front());
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      logic [63:0] d;
      logic [63:0] m;
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_op    = 1'b0;
      in_wide  = 1'b1;
      in_data  = '0;
      in_mask  = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset out_result", out_result, 64'd0);
      rst_n = 1'b1;
      idle(1);
      check("R1 idle after reset", {63'd0, out_valid}, 64'd0);

      // R10: worked example
      send(1'b0, 1'b1, 64'hB6, 64'h65, 64'h06, "R10 gather example");
      send(1'b1, 1'b1, 64'hB6, 64'h65, 64'h24, "R10 scatter example");
      send(1'b0, 1'b0, 64'hFFFF_FF00_0000_00B6, 64'hFF00_0000_0000_0065, 64'h06,
           "R10 R6 gather example narrow");

      // R7: zero mask
      send(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, "R7 gather zero mask");
      send(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, "R7 scatter zero mask");
      send(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h0,
           "R7 R6 scatter narrow upper-only mask");

      // R8: all-ones mask
      send(1'b0, 1'b1, 64'hDEAD_BEEF_0123_4567, '1, 64'hDEAD_BEEF_0123_4567, "R8 gather full");
      send(1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567, '1, 64'hDEAD_BEEF_0123_4567, "R8 scatter full");
      send(1'b0, 1'b0, 64'hDEAD_BEEF_0123_4567, '1, 64'h0000_0000_0123_4567, "R8 R6 gather full narrow");
      send(1'b1, 1'b0, 64'hDEAD_BEEF_0123_4567, '1, 64'h0000_0000_0123_4567, "R8 R6 scatter full narrow");

      // R2/R3/R4/R5 boundaries: single top bit, single bottom bit, alternating
      send(1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h1, "R2 gather top bit");
      send(1'b1, 1'b1, 64'h1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R4 scatter top bit");
      send(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_FFFF_FFFF,
           "R3 gather alternating");
      send(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555,
           "R5 scatter alternating");
      send(1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0001, 64'h2,
           "R6 gather narrow bit 31");
      idle(2);

      // Random back-to-back traffic with bursts and sparse/dense masks
      for (int t = 0; t < 400; t++) begin
         d = rnd64();
         m = rnd64();
         case (t % 4)
            1: m = m & rnd64();
            2: m = m | rnd64();
            default: ;
         endcase
         send_ref(t[0] ^ t[3], (t % 3) != 0, d, m,
                  (t[0] ^ t[3]) ? "R4 R5 scatter random" : "R2 R3 gather random");
         if (t % 37 == 0) idle(1);
      end
      idle(3);

      // R9: hold with valid low while operands churn
      held = out_result;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_op    = ~in_op;
         in_data  = rnd64();
         in_mask  = rnd64();
      end
      @(negedge clk);
      check("R9 hold during idle", out_result, held);
      check("R1 no valid during idle", {63'd0, out_valid}, 64'd0);
      check("R1 scoreboard drained", 64'(exp_q.size()), 64'd0);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule